// File: doc/BRIEF.md
# Write-Recovery Precharge Guard

This block sits in the command path of a DDR2-style memory controller. It decides, for each of eight banks, whether a PRECHARGE may be issued yet. The decision depends on the most recent WRITE to that bank. The block watches the command bus, the bank address, the A10 bit and the programmed latency and burst settings. From these it works out the clock in which the last data-in pair of each write burst has landed. It then counts the write-recovery interval from the first rising edge after that pair.

While a bank is recovering, its precharge-allowed bit is low. A PRECHARGE aimed at that bank is then stalled. A PRECHARGE aimed at any other bank passes in the same cycle. An all-bank PRECHARGE is granted only when every bank is clear.

Write latency is taken as CL + AL − 1. To cover the latest legal strobe placement, one extra clock is always added after the data-in pairs. A write that carries auto-precharge (A10 high) is left to the device and is not tracked. The settings must be held steady while any bank is recovering.

Top module: `wr_recovery_guard`

## Requirements
- R1: After reset every bit of `pre_ok` is 1, and `pre_grant` and `pre_stall` are 0 while no PRECHARGE is presented.
- R2: `cmd` is decoded as 3'd1 = WRITE and 3'd2 = PRECHARGE. Every other code (NOP = 3'd0, and 3'd3 to 3'd7) changes no bank's state.
- R3: A WRITE with `a10` = 0 to bank b in cycle T clears `pre_ok[b]` from cycle T+1. The bit rises again in cycle T+D, where D = CL + AL + BL/2 + tWR. This is write latency (CL+AL−1), plus BL/2 data clocks, plus one clock of strobe slack, plus tWR.
- R4: A WRITE to bank b leaves `pre_ok` of every other bank unchanged.
- R5: A second WRITE to a bank that is still recovering restarts its window. The bank then reopens D cycles after the second write.
- R6: A PRECHARGE with `a10` = 0 gives `pre_grant` = `pre_ok[bank]` and `pre_stall` = its inverse, in the same cycle.
- R7: A PRECHARGE with `a10` = 1 (all banks) is granted only when all eight `pre_ok` bits are 1. Otherwise it is stalled.
- R8: A WRITE with `a10` = 1 (auto-precharge) does not close the bank's `pre_ok`.
- R9: `twr` is clamped to the range 2 to 8 clocks. Values 0 and 1 act as 2, and values above 8 act as 8.
- R10: `burst8` = 0 selects BL4 (BL/2 = 2) and `burst8` = 1 selects BL8 (BL/2 = 4).
- R11: `pre_grant` and `pre_stall` are never both high, and both are low in any cycle without a PRECHARGE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command code (1 WRITE, 2 PRECHARGE, others ignored) |
| bank | input | 3 | Bank address of the command |
| a10 | input | 1 | Auto-precharge flag on WRITE, all-bank flag on PRECHARGE |
| cas_lat | input | 3 | CAS latency in clocks (2 or more) |
| add_lat | input | 3 | Additive latency in clocks |
| burst8 | input | 1 | 1 selects burst length 8, 0 selects burst length 4 |
| twr | input | 4 | Write-recovery time in clocks, clamped to 2 to 8 |
| pre_ok | output | 8 | Per-bank precharge-allowed flags |
| pre_grant | output | 1 | Presented PRECHARGE may issue this cycle |
| pre_stall | output | 1 | Presented PRECHARGE must be held back |

## Verification
Each bank's tracker state is visible at the ports every cycle through `pre_ok`. A counter that is loaded one value off, or that changes phase one cycle off, moves the rising edge of that bit. That error shows in the first cycle where the edge is expected, at most D cycles after the write.

If a tracker locks up, its bank keeps stalling PRECHARGE until well past the deadline. An all-bank request also stays stalled. If a write arms the wrong bank, the stall appears on a neighbour in the very next cycle. The bench compares all eight bits, the grant and the stall against a per-bank remaining-cycles model on every cycle.

// File: rtl/wrg_pkg.sv
`timescale 1ns/1ps
package wrg_pkg;
    localparam int NUM_BANKS_DEF = 8;
    localparam int CNT_W         = 5;
    localparam int TWR_W         = 4;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_WRITE = 3'd1,
        CMD_PRE   = 3'd2
    } cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LAND = 2'd1,
        PH_REC  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
    } bank_st_t;
endpackage

// File: rtl/wrg_timing.sv
`timescale 1ns/1ps
module wrg_timing
    import wrg_pkg::*;
#(
    parameter int TWR_MIN      = 2,
    parameter int TWR_MAX      = 8,
    parameter int STROBE_SLACK = 1
) (
    input  logic [2:0]        cas_lat,
    input  logic [2:0]        add_lat,
    input  logic              burst8,
    input  logic [TWR_W-1:0]  twr,
    output logic [CNT_W-1:0]  land_load,
    output logic [CNT_W-1:0]  rec_load
);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
    localparam logic [CNT_W-1:0] SLACK  = CNT_W'(STROBE_SLACK);
    localparam logic [CNT_W-1:0] HALF4  = CNT_W'(2);
    localparam logic [CNT_W-1:0] HALF8  = CNT_W'(4);
    localparam logic [TWR_W-1:0] LO     = TWR_W'(TWR_MIN);
    localparam logic [TWR_W-1:0] HI     = TWR_W'(TWR_MAX);

    logic [CNT_W-1:0] wl;
    logic [CNT_W-1:0] half_bl;
    logic [TWR_W-1:0] twr_c;

    always_comb begin
        // write latency = CL + AL - 1
        wl      = CNT_W'(cas_lat) + CNT_W'(add_lat) - ONE;
        half_bl = burst8 ? HALF8 : HALF4;
        // cycles until recovery start, minus the load cycle
        land_load = wl + half_bl + SLACK - ONE;

        if (twr < LO)      twr_c = LO;
        else if (twr > HI) twr_c = HI;
        else               twr_c = twr;
        rec_load = CNT_W'(twr_c) - ONE;
    end
endmodule

// File: rtl/wrg_bank.sv
`timescale 1ns/1ps
module wrg_bank
    import wrg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [CNT_W-1:0]  land_load,
    input  logic [CNT_W-1:0]  rec_load,
    output logic              ok
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (arm) begin
            st_d.phase = PH_LAND;
            st_d.cnt   = land_load;
        end else begin
            case (st_q.phase)
                PH_LAND: begin
                    if (st_q.cnt == '0) begin
                        st_d.phase = PH_REC;
                        st_d.cnt   = rec_load;
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                    end
                end
                PH_REC: begin
                    if (st_q.cnt == '0) begin
                        st_d.phase = PH_IDLE;
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                    end
                end
                default: begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ok = (st_q.phase == PH_IDLE) ||
                (st_q.phase == PH_REC && st_q.cnt == '0);
endmodule

// File: rtl/wrg_arb.sv
`timescale 1ns/1ps
module wrg_arb #(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic                 is_pre,
    input  logic                 all_banks,
    input  logic [BANK_W-1:0]    bank,
    input  logic [NUM_BANKS-1:0] ok,
    output logic                 grant,
    output logic                 stall
);
    logic allowed;

    always_comb begin
        allowed = all_banks ? (&ok) : ok[bank];
        grant   = is_pre &  allowed;
        stall   = is_pre & ~allowed;
    end
endmodule

// File: rtl/wr_recovery_guard.sv
`timescale 1ns/1ps
module wr_recovery_guard
    import wrg_pkg::*;
#(
    parameter int NUM_BANKS = NUM_BANKS_DEF,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            cmd,
    input  logic [BANK_W-1:0]     bank,
    input  logic                  a10,
    input  logic [2:0]            cas_lat,
    input  logic [2:0]            add_lat,
    input  logic                  burst8,
    input  logic [TWR_W-1:0]      twr,
    output logic [NUM_BANKS-1:0]  pre_ok,
    output logic                  pre_grant,
    output logic                  pre_stall
);
    logic [CNT_W-1:0] land_load;
    logic [CNT_W-1:0] rec_load;
    logic             is_wr_tracked;
    logic             is_pre;

    assign is_wr_tracked = (cmd == CMD_WRITE) && !a10;
    assign is_pre        = (cmd == CMD_PRE);

    wrg_timing u_timing (
        .cas_lat   (cas_lat),
        .add_lat   (add_lat),
        .burst8    (burst8),
        .twr       (twr),
        .land_load (land_load),
        .rec_load  (rec_load)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        wrg_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .arm       (is_wr_tracked && (bank == BANK_W'(g))),
            .land_load (land_load),
            .rec_load  (rec_load),
            .ok        (pre_ok[g])
        );
    end

    wrg_arb #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_arb (
        .is_pre    (is_pre),
        .all_banks (a10),
        .bank      (bank),
        .ok        (pre_ok),
        .grant     (pre_grant),
        .stall     (pre_stall)
    );
endmodule

// File: rtl/wrg_chk.sv
`timescale 1ns/1ps
module wrg_chk
    import wrg_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [2:0]            cmd,
    input logic [BANK_W-1:0]     bank,
    input logic                  a10,
    input logic [NUM_BANKS-1:0]  pre_ok,
    input logic                  pre_grant,
    input logic                  pre_stall
);
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_b
        // R3
        wr_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd == CMD_WRITE && !a10 && bank == BANK_W'(g)) |=> !pre_ok[g]);
        // R4
        open_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_ok[g] && !(cmd == CMD_WRITE && !a10 && bank == BANK_W'(g))) |=> pre_ok[g]);
    end

    // R6
    one_bank_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE && !a10) |-> (pre_grant == pre_ok[bank]));

    // R7
    all_bank_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE && a10) |-> (pre_grant == (&pre_ok)));

    // R11
    grant_stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pre_grant && pre_stall));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_PRE) |-> (!pre_grant && !pre_stall));
endmodule

bind wr_recovery_guard wrg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .bank      (bank),
    .a10       (a10),
    .pre_ok    (pre_ok),
    .pre_grant (pre_grant),
    .pre_stall (pre_stall)
);

// File: tb/sim_wr_recovery_guard.sv
`timescale 1ns/1ps
module sim_wr_recovery_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic [2:0] bank = 3'd0;
    logic       a10 = 1'b0;
    logic [2:0] cas_lat = 3'd3;
    logic [2:0] add_lat = 3'd0;
    logic       burst8 = 1'b0;
    logic [3:0] twr = 4'd2;
    logic [7:0] pre_ok;
    logic       pre_grant;
    logic       pre_stall;

    int n_chk = 0;
    int n_err = 0;
    int rem [8];

    always #4 clk = ~clk;

    wr_recovery_guard u0 (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .a10(a10),
        .cas_lat(cas_lat), .add_lat(add_lat), .burst8(burst8), .twr(twr),
        .pre_ok(pre_ok), .pre_grant(pre_grant), .pre_stall(pre_stall)
    );

    function automatic int twr_eff(input int t);
        if (t < 2) return 2;
        if (t > 8) return 8;
        return t;
    endfunction

    // R3 window length: CL + AL + BL/2 + tWR
    function automatic int win_len();
        return int'(cas_lat) + int'(add_lat) + (burst8 ? 4 : 2) + twr_eff(int'(twr));
    endfunction

    task automatic step(input logic [2:0] c, input logic [2:0] b,
                        input logic a, input string tag);
        logic [7:0] exp_ok;
        logic       allowed, exp_g, exp_s;
        @(negedge clk);
        cmd = c; bank = b; a10 = a;
        #1;
        for (int i = 0; i < 8; i++) exp_ok[i] = (rem[i] == 0);
        allowed = a ? (&exp_ok) : exp_ok[b];
        exp_g = (c == 3'd2) && allowed;
        exp_s = (c == 3'd2) && !allowed;
        n_chk++;
        if ({pre_ok, pre_grant, pre_stall} !== {exp_ok, exp_g, exp_s}) begin
            n_err++;
            $display("FAIL %s ok/grant/stall got %b/%b/%b exp %b/%b/%b",
                     tag, pre_ok, pre_grant, pre_stall, exp_ok, exp_g, exp_s);
        end
        @(posedge clk);
        for (int i = 0; i < 8; i++) begin
            if (c == 3'd1 && !a && b == 3'(i)) rem[i] = win_len() - 1;
            else if (rem[i] > 0) rem[i] = rem[i] - 1;
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step(3'd0, 3'd0, 1'b0, tag);
    endtask

    task automatic set_cfg(input int cl, input int al, input logic b8, input int t);
        cas_lat = 3'(cl); add_lat = 3'(al); burst8 = b8; twr = 4'(t);
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int grant_at;
        for (int i = 0; i < 8; i++) rem[i] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        idle(2, "R1");

        // R3/R4/R6: CL3 AL0 BL4 tWR2 -> reopens 7 cycles after write
        set_cfg(3, 0, 1'b0, 2);
        step(3'd1, 3'd2, 1'b0, "R3");
        step(3'd2, 3'd5, 1'b0, "R4");
        grant_at = 0;
        for (int k = 2; k <= 9; k++) begin
            step(3'd2, 3'd2, 1'b0, "R6");
            if (pre_grant && grant_at == 0) grant_at = k;
        end
        n_chk++;
        if (grant_at != 7) begin
            n_err++;
            $display("FAIL R3 first grant cycle got %0d exp 7", grant_at);
        end
        idle(30, "R3");

        // R10: BL8, CL4 AL1 tWR3
        set_cfg(4, 1, 1'b1, 3);
        step(3'd1, 3'd0, 1'b0, "R10");
        for (int k = 0; k < 14; k++) step(3'd2, 3'd0, 1'b0, "R10");
        idle(30, "R10");

        // R9: clamp low and high
        set_cfg(3, 0, 1'b0, 0);
        step(3'd1, 3'd7, 1'b0, "R9");
        for (int k = 0; k < 10; k++) step(3'd2, 3'd7, 1'b0, "R9");
        idle(30, "R9");
        set_cfg(3, 0, 1'b0, 15);
        step(3'd1, 3'd7, 1'b0, "R9");
        for (int k = 0; k < 16; k++) step(3'd2, 3'd7, 1'b0, "R9");
        idle(30, "R9");

        // R5: rewrite restarts the window
        set_cfg(3, 2, 1'b0, 4);
        step(3'd1, 3'd1, 1'b0, "R5");
        idle(3, "R5");
        step(3'd1, 3'd1, 1'b0, "R5");
        for (int k = 0; k < 14; k++) step(3'd2, 3'd1, 1'b0, "R5");
        idle(30, "R5");

        // R7: all-bank precharge waits for the slowest bank
        step(3'd1, 3'd3, 1'b0, "R7");
        idle(4, "R7");
        step(3'd1, 3'd6, 1'b0, "R7");
        for (int k = 0; k < 14; k++) step(3'd2, 3'd0, 1'b1, "R7");
        idle(30, "R7");

        // R8: auto-precharge write is not tracked
        step(3'd1, 3'd4, 1'b1, "R8");
        step(3'd2, 3'd4, 1'b0, "R8");
        step(3'd2, 3'd4, 1'b0, "R8");

        // R2: other codes leave banks untouched
        for (int c = 3; c < 8; c++) step(3'(c), 3'd4, 1'b0, "R2");
        step(3'd0, 3'd4, 1'b0, "R2");
        step(3'd2, 3'd4, 1'b1, "R2");

        // Random mix, checked against the per-bank model
        void'($urandom(32'd7741));
        for (int blk = 0; blk < 25; blk++) begin
            set_cfg(3 + int'($urandom % 4), int'($urandom % 5),
                    1'($urandom % 2), int'($urandom % 16));
            for (int k = 0; k < 60; k++) begin
                int r;
                logic [2:0] c;
                r = int'($urandom % 8);
                if (r < 3)      c = 3'd1;
                else if (r < 6) c = 3'd2;
                else            c = 3'($urandom % 8);
                step(c, 3'($urandom % 8), 1'($urandom % 4 == 0), "R11");
            end
            idle(40, "R11");
        end

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule